// File: doc/BRIEF.md
# Three-Phase Power-Frequency Phase Generator

This block keeps the running power-frequency angle for a three-phase PWM generator. On each carrier-rate strobe it adds a step to a phase accumulator. The step is the speed word scaled by a power-of-two range factor, and the range factor is chosen by a 3-bit code. One full wrap of the 16-bit accumulator is 360 degrees. The block outputs three angles spaced a third of a turn apart (red, yellow, blue). Downstream waveform lookup and carrier comparison use these angles.

A small state machine turns the counter-reset and inhibit inputs into a gating signal for the PWM stage. The states are `ST_HOLD`, `ST_RUN` and `ST_MUTED`:
- `ST_HOLD` is entered whenever the counter reset is low, and the accumulator is held at zero there.
- `ST_RUN` is entered from any state when the counter reset is high and inhibit is low.
- `ST_MUTED` is entered from any state when the counter reset is high and inhibit is high.

The transitions are named HOLD_ENTER, RUN_ENTER and MUTE_ENTER. The accumulator keeps advancing in `ST_MUTED`, so the angle stays current when the gate reopens. The direction bit swaps the yellow and blue angles, which reverses the phase order. The overmodulation request is registered and passed on as an amplitude-doubling flag while the gate is open.

Top module: `pf_phase_gen`

## Requirements
- R1: The accumulator changes only in a cycle whose strobe is high. With the strobe low, all three angle outputs are stable on the next cycle.
- R2: On a strobe with the counter reset high, the red angle advances modulo 65536 by speed × m one clock later. The range code sets m: 000→1, 001→2, 010→4, 011→8, 100→16, 101→32, 110→64.
- R3: Range code 111 gives the same step as 110 (m = 64).
- R4: While the counter reset is low, the red angle reads 0 from the next clock and stays at 0. Counting restarts from 0 after the reset goes high.
- R5: When the direction bit is 0, yellow = red + 21845 and blue = red + 43691, both modulo 65536.
- R6: When the direction bit is 1, yellow = red + 43691 and blue = red + 21845. The direction bit has no effect on red.
- R7: The gate output is high one clock after a cycle with the counter reset high and inhibit low, and is low otherwise. Inhibit does not stop accumulation.
- R8: The amplitude-doubling output equals the overmodulation input of the previous cycle ANDed with the gate output.
- R9: During and just after the asynchronous reset, all angles read red = 0 and the gate and amplitude flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_stb_i | input | 1 | Carrier-rate advance strobe |
| range_sel_i | input | 3 | Range multiplier code |
| speed_i | input | 8 | Speed (phase step) word |
| cnt_rst_n_i | input | 1 | Active-low phase counter reset |
| reverse_i | input | 1 | Phase order select (1 = reverse) |
| overmod_i | input | 1 | Overmodulation request |
| inhibit_i | input | 1 | Output inhibit |
| phase_red_o | output | 16 | Red phase angle |
| phase_yel_o | output | 16 | Yellow phase angle |
| phase_blu_o | output | 16 | Blue phase angle |
| pwm_gate_o | output | 1 | Gate enable for the PWM stage |
| amp_double_o | output | 1 | Amplitude doubling flag |

## Verification
Two functions can land in the same cycle: accumulation and the closing of the gate by inhibit. The bench provokes this by applying strobes while inhibit is high. It expects the gate to drop while the red angle keeps advancing by the scaled step, and checks both outputs in the same sampled cycle. A second collision is a strobe arriving while the counter reset is low. Here the bench expects the hold to win and the red angle to read zero.

// File: rtl/pf_phase_pkg.sv
package pf_phase_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_MUTED = 2'd2
    } pf_state_e;

    // Range code to left-shift amount; the spare code saturates at the top range.
    function automatic logic [2:0] range_shift(input logic [2:0] code);
        return (code == 3'b111) ? 3'd6 : code;
    endfunction
endpackage

// File: rtl/pf_step_scale.sv
module pf_step_scale #(
    parameter int ACC_W   = 16,
    parameter int SPEED_W = 8
) (
    input  logic [SPEED_W-1:0] speed_i,
    input  logic [2:0]         range_sel_i,
    output logic [ACC_W-1:0]   inc_o
);
    import pf_phase_pkg::*;

    logic [ACC_W-1:0] speed_ext;
    logic [2:0]       shamt;

    always_comb begin
        speed_ext = ACC_W'(speed_i);
        shamt     = range_shift(range_sel_i);
        inc_o     = speed_ext << shamt;
    end
endmodule

// File: rtl/pf_phase_acc.sv
module pf_phase_acc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             stb_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
        end else if (hold_i) begin
            acc_o <= '0;
        end else if (stb_i) begin
            acc_o <= acc_o + inc_i;
        end
    end

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (acc_o == '0)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !stb_i) |=> $stable(acc_o)); // R1
    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && stb_i) |=> (acc_o == ACC_W'($past(acc_o) + $past(inc_i)))); // R2
endmodule

// File: rtl/pf_phase_fsm.sv
module pf_phase_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_rst_n_i,
    input  logic inhibit_i,
    output logic hold_o,
    output logic gate_o
);
    import pf_phase_pkg::*;

    pf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!cnt_rst_n_i)   state_d = ST_HOLD;   // HOLD_ENTER
        else if (inhibit_i) state_d = ST_MUTED;  // MUTE_ENTER
        else                state_d = ST_RUN;    // RUN_ENTER
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD:  gate_o = 1'b0;
            ST_RUN:   gate_o = 1'b1;
            ST_MUTED: gate_o = 1'b0;
            default:  gate_o = 1'b0;
        endcase
    end

    assign hold_o = !cnt_rst_n_i;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3); // R7
endmodule

// File: rtl/pf_phase_map.sv
module pf_phase_map #(
    parameter int ACC_W = 16
) (
    input  logic [ACC_W-1:0] red_i,
    input  logic             reverse_i,
    output logic [ACC_W-1:0] red_o,
    output logic [ACC_W-1:0] yel_o,
    output logic [ACC_W-1:0] blu_o
);
    localparam longint TURN = longint'(1) << ACC_W;
    localparam logic [ACC_W-1:0] OFS_120 = ACC_W'((TURN + 1) / 3);
    localparam logic [ACC_W-1:0] OFS_240 = ACC_W'((2 * TURN + 1) / 3);

    logic [ACC_W-1:0] lag1, lag2;

    always_comb begin
        lag1  = red_i + OFS_120;
        lag2  = red_i + OFS_240;
        red_o = red_i;
        yel_o = reverse_i ? lag2 : lag1;
        blu_o = reverse_i ? lag1 : lag2;
    end
endmodule

// File: rtl/pf_phase_gen.sv
module pf_phase_gen #(
    parameter int ACC_W   = 16,
    parameter int SPEED_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               carrier_stb_i,
    input  logic [2:0]         range_sel_i,
    input  logic [SPEED_W-1:0] speed_i,
    input  logic               cnt_rst_n_i,
    input  logic               reverse_i,
    input  logic               overmod_i,
    input  logic               inhibit_i,
    output logic [ACC_W-1:0]   phase_red_o,
    output logic [ACC_W-1:0]   phase_yel_o,
    output logic [ACC_W-1:0]   phase_blu_o,
    output logic               pwm_gate_o,
    output logic               amp_double_o
);
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] acc;
    logic             hold;
    logic             ovm_q;

    pf_step_scale #(.ACC_W(ACC_W), .SPEED_W(SPEED_W)) u_scale (
        .speed_i(speed_i), .range_sel_i(range_sel_i), .inc_o(inc));

    pf_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cnt_rst_n_i(cnt_rst_n_i),
        .inhibit_i(inhibit_i), .hold_o(hold), .gate_o(pwm_gate_o));

    pf_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .hold_i(hold), .stb_i(carrier_stb_i),
        .inc_i(inc), .acc_o(acc));

    pf_phase_map #(.ACC_W(ACC_W)) u_map (
        .red_i(acc), .reverse_i(reverse_i),
        .red_o(phase_red_o), .yel_o(phase_yel_o), .blu_o(phase_blu_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovm_q <= 1'b0;
        else        ovm_q <= overmod_i;
    end

    assign amp_double_o = ovm_q & pwm_gate_o;

    AST_INHIBIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !pwm_gate_o); // R7
    AST_HOLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rst_n_i |=> (!pwm_gate_o && phase_red_o == '0)); // R4
    AST_AMP_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        amp_double_o |-> pwm_gate_o); // R8
    AST_DIR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_yel_o != phase_blu_o)); // R6
endmodule

// File: tb/pf_phase_gen_tb.sv
module pf_phase_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [2:0]  rsel = 3'd0;
    logic [7:0]  spd = 8'd0;
    logic        crn = 1'b0;
    logic        rev = 1'b0;
    logic        ovm = 1'b0;
    logic        inh = 1'b0;
    logic [15:0] red, yel, blu;
    logic        gate, amp;

    int checks = 0;
    int fails  = 0;
    logic [15:0] acc_m = 16'd0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] r, y, b;
        logic        g, a;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    pf_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .carrier_stb_i(stb), .range_sel_i(rsel),
        .speed_i(spd), .cnt_rst_n_i(crn), .reverse_i(rev), .overmod_i(ovm),
        .inhibit_i(inh), .phase_red_o(red), .phase_yel_o(yel),
        .phase_blu_o(blu), .pwm_gate_o(gate), .amp_double_o(amp));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result after the next edge.
    task automatic drive(string tag, logic s, logic [2:0] rs, logic [7:0] sp,
                         logic cr, logic dr, logic ov, logic ih);
        exp_t e;
        int   sh;
        @(negedge clk);
        stb = s; rsel = rs; spd = sp; crn = cr; rev = dr; ovm = ov; inh = ih;
        sh = (rs == 3'b111) ? 6 : int'(rs);
        if (!cr)   acc_m = 16'd0;
        else if (s) acc_m = acc_m + 16'(32'(sp) << sh);
        e.r = acc_m;
        e.y = dr ? acc_m + 16'd43691 : acc_m + 16'd21845;
        e.b = dr ? acc_m + 16'd21845 : acc_m + 16'd43691;
        e.g = cr & !ih;
        e.a = ov & cr & !ih;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " red"}, 64'(red), 64'(e.r));
                check({e.tag, " yel"}, 64'(yel), 64'(e.y));
                check({e.tag, " blu"}, 64'(blu), 64'(e.b));
                check({e.tag, " gate"}, 64'(gate), 64'(e.g));
                check({e.tag, " amp"}, 64'(amp), 64'(e.a));
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 red", 64'(red), 64'd0);
        check("R9 gate", 64'(gate), 64'd0);
        check("R9 amp", 64'(amp), 64'd0);
        rst_n = 1'b1;
        // R4: held while counter reset low, strobes ignored
        drive("R4 hold", 1, 3'd2, 8'd9, 0, 0, 0, 0);
        drive("R4 hold", 1, 3'd2, 8'd9, 0, 0, 0, 0);
        // R2: every range code with one strobe
        for (int c = 0; c < 7; c++) drive("R2 step", 1, 3'(c), 8'd5, 1, 0, 0, 0);
        // R3: spare code saturates
        drive("R3 code7", 1, 3'd7, 8'd3, 1, 0, 0, 0);
        // R1: no strobe, no movement
        drive("R1 idle", 0, 3'd6, 8'd200, 1, 0, 0, 0);
        drive("R1 idle", 0, 3'd6, 8'd200, 1, 0, 0, 0);
        // R5/R6: direction
        drive("R5 fwd", 1, 3'd1, 8'd77, 1, 0, 0, 0);
        drive("R6 rev", 1, 3'd1, 8'd77, 1, 1, 0, 0);
        drive("R6 rev", 0, 3'd1, 8'd77, 1, 1, 0, 0);
        // R8: overmodulation
        drive("R8 ovm", 1, 3'd0, 8'd1, 1, 0, 1, 0);
        // R7: inhibit with strobes: gate drops, accumulation continues
        drive("R7 inh", 1, 3'd4, 8'd11, 1, 0, 1, 1);
        drive("R7 inh", 1, 3'd4, 8'd11, 1, 0, 0, 1);
        drive("R7 resume", 1, 3'd4, 8'd11, 1, 0, 0, 0);
        // R4: reset mid-run then restart from zero
        drive("R4 mid", 1, 3'd5, 8'd50, 0, 0, 0, 0);
        drive("R4 restart", 1, 3'd0, 8'd4, 1, 0, 0, 0);
        // R2: wraparound at the top range
        for (int i = 0; i < 10; i++) drive("R2 wrap", 1, 3'd6, 8'd255, 1, i[0], 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule